// File: doc/BRIEF.md
# Offset-Add and Overrange Clip Unit

This block sits after a successive-approximation converter and turns each fresh 12-bit raw code into the 13-bit word placed on the data bus. A programmable signed offset is added to every raw code. The offset is loaded through a 13-bit write word whose low 10 bits carry the offset in two's complement. The sum is then either saturated to the 12-bit range or passed on with one extra bit, so that inputs about 8% beyond either end of the nominal range can still be resolved.

A one-cycle conversion strobe carries the raw code and the clip-mode selection into the unit. One clock later the shaped result is registered on the output together with a one-cycle valid strobe. The output holds its value until the next conversion. A write word that is malformed or out of range is refused: the stored offset is kept and an error pulse is issued.

Top module: `ofsclp_top`

## Requirements
- R1: After reset `result` is 0, `result_vld` is 0, `wr_err` is 0 and the stored offset is zero. With a zero offset and clip enabled, the output is the raw code with bit 12 cleared.
- R2: `result_vld` is high for exactly the one cycle after each cycle in which `conv_done` is high. `result` changes only in that cycle and holds its value otherwise.
- R3: A write word is accepted when bits 12..10 are zero and bits 9..0, read as a two's-complement number, lie within -327..+327 (for example, 1110000000 is -128 and 0001000000 is +64). An accepted offset applies to conversions strobed in later cycles. A conversion strobed in the same cycle as the write still uses the previous offset.
- R4: A write word with any of bits 12..10 set, or with an offset outside -327..+327, leaves the stored offset unchanged and drives `wr_err` high for the one cycle after the write. An accepted write leaves `wr_err` low.
- R5: With `clip_en` high and 0 <= raw+offset <= 4095, `result` is the sum with bit 12 = 0.
- R6: With `clip_en` high, a sum above 4095 gives `result` = 0x1FFF (all ones plus flag), and a sum below 0 gives `result` = 0x1000 (zero code plus flag). Bit 12 set means out of nominal range.
- R7: With `clip_en` low, `result` is the sum modulo 8192. Sums of 4096..4422 appear as 0x1000..0x1146, and sums of -327..-1 appear as 0x1EB9..0x1FFF, so the two overrange sides stay separable.
- R8: `clip_en` is sampled only in the `conv_done` cycle. Changing it later has no effect on the held `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Offset write strobe |
| wr_word | input | 13 | Offset write word (bits 9..0 two's-complement offset, bits 12..10 must be zero) |
| conv_done | input | 1 | One-cycle strobe: a new raw code is present |
| raw_code | input | 12 | Raw converter code, straight binary |
| clip_en | input | 1 | 1 = saturate with range flag, 0 = keep extended sum |
| result | output | 13 | Shaped output word |
| result_vld | output | 1 | One-cycle strobe that marks a new `result` |
| wr_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest situation to reach is a conversion and an offset write in the same cycle, because the outcome depends on which offset the adder sees at that edge. The bench drives both strobes on one edge and checks that the first result uses the old offset and the next one uses the new offset. All 1024 values of the offset field are written and probed through a mid-scale conversion. Every raw code is then swept under both range extremes and several other offsets in both clip modes, so both saturation boundaries and both wrap regions are crossed.

// File: rtl/ofsclp_pkg.sv
// Package: shared types for the offset-add and clip unit.
// Assumes: the offset magnitude limit is below the raw full scale, so a
// sum can overflow on at most one side at a time.
package ofsclp_pkg;

    // Range class of a raw+offset sum relative to the nominal code range
    typedef enum logic [1:0] {
        RNG_IN   = 2'd0,
        RNG_LOW  = 2'd1,
        RNG_HIGH = 2'd2
    } rng_cls_t;

endpackage

// File: rtl/ofsclp_ofs_reg.sv
// Module: ofsclp_ofs_reg
// Validates and stores the programmable offset. A word is accepted only if
// its upper bits are zero and its signed field lies within +/-OFS_LIMIT.
// Refused words keep the old value and raise a one-cycle error pulse.
// Assumes: OFS_LIMIT < 2**(OFS_W-1).
module ofsclp_ofs_reg #(
    parameter int OFS_W     = 10,
    parameter int WORD_W    = 13,
    parameter int OFS_LIMIT = 327
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WORD_W-1:0]       wr_word,
    output logic signed [OFS_W-1:0] ofs_q,
    output logic                    wr_err
);

    localparam int HI_W = WORD_W - OFS_W;

    logic signed [OFS_W-1:0] field;
    logic                    hi_clear;
    logic                    in_range;
    logic                    accept;

    // Decode the write word and judge whether it is legal
    always_comb begin
        field    = $signed(wr_word[OFS_W-1:0]);
        hi_clear = (wr_word[WORD_W-1:OFS_W] == '0);
        in_range = (int'(field) >= -OFS_LIMIT) && (int'(field) <= OFS_LIMIT);
        accept   = hi_clear && in_range;
    end

    // Offset storage: updated only by an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (wr_en && accept) begin
            ofs_q <= field;
        end
    end

    // Error pulse for a refused write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && !accept;
        end
    end

    // R4: a write flagged as an error leaves the stored offset unchanged
    a_r4_keep_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $stable(ofs_q));

    // R4: an error pulse only follows a write strobe
    a_r4_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    // R3: the stored offset never leaves the legal window
    a_r3_ofs_window: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ofs_q) >= -OFS_LIMIT) && (int'(ofs_q) <= OFS_LIMIT));

    // R3: upper bits set never lead to an offset change
    a_r3_hi_bits_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_word[WORD_W-1:OFS_W] != '0)) |=> $stable(ofs_q));

    // Unused-width guard: keeps HI_W referenced for readers
    initial begin
        assert (HI_W > 0) else $error("write word must be wider than the offset field");
    end

endmodule

// File: rtl/ofsclp_adder.sv
// Module: ofsclp_adder
// Adds the unsigned raw code and the signed offset in a width that cannot
// overflow, and classifies the sum against the nominal code range.
// Assumes: |offset| < 2**RAW_W, so bit RAW_W of a non-negative sum marks
// "above full scale" and the top bit marks "below zero".
module ofsclp_adder
    import ofsclp_pkg::*;
#(
    parameter int RAW_W = 12,
    parameter int OFS_W = 10
) (
    input  logic [RAW_W-1:0]        raw_code,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [RAW_W:0]          sum_lo,
    output rng_cls_t                cls
);

    localparam int SUM_W = RAW_W + 2;

    logic signed [SUM_W-1:0] raw_ext;
    logic signed [SUM_W-1:0] ofs_ext;
    logic signed [SUM_W-1:0] sum;

    // Extend both operands and form the exact sum
    always_comb begin
        raw_ext = $signed({2'b00, raw_code});
        ofs_ext = $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
        sum     = raw_ext + ofs_ext;
    end

    // Classify the sum: negative, beyond full scale, or nominal
    always_comb begin
        if (sum[SUM_W-1]) begin
            cls = RNG_LOW;
        end else if (sum[RAW_W]) begin
            cls = RNG_HIGH;
        end else begin
            cls = RNG_IN;
        end
        sum_lo = sum[RAW_W:0];
    end

endmodule

// File: rtl/ofsclp_shaper.sv
// Module: ofsclp_shaper
// Forms the output word from the sum. In clip mode it saturates to the
// nominal range and sets the top bit as a range flag; otherwise it passes
// the sum modulo 2**(RAW_W+1).
// Assumes: cls is consistent with sum_lo as produced by ofsclp_adder.
module ofsclp_shaper
    import ofsclp_pkg::*;
#(
    parameter int RAW_W = 12
) (
    input  logic [RAW_W:0] sum_lo,
    input  rng_cls_t       cls,
    input  logic           clip_en,
    output logic [RAW_W:0] shaped
);

    // Select saturated or extended form of the sum
    always_comb begin
        if (clip_en) begin
            unique case (cls)
                RNG_LOW:  shaped = {1'b1, {RAW_W{1'b0}}};
                RNG_HIGH: shaped = {1'b1, {RAW_W{1'b1}}};
                default:  shaped = {1'b0, sum_lo[RAW_W-1:0]};
            endcase
        end else begin
            shaped = sum_lo;
        end
    end

endmodule

// File: rtl/ofsclp_top.sv
// Module: ofsclp_top
// Offset-add and overrange clip unit. Each conversion strobe captures the
// shaped (raw + offset) word into the output register one cycle later,
// together with a one-cycle valid strobe. The offset is held in a
// validated register that resets to zero.
// Assumes: conv_done is a single-cycle strobe per conversion; clip_en is
// meaningful only in that cycle.
module ofsclp_top #(
    parameter int RAW_W     = 12,
    parameter int OFS_W     = 10,
    parameter int WORD_W    = 13,
    parameter int OFS_LIMIT = 327
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  raw_code,
    input  logic              clip_en,
    output logic [RAW_W:0]    result,
    output logic              result_vld,
    output logic              wr_err
);

    import ofsclp_pkg::*;

    localparam int OUT_W = RAW_W + 1;

    logic signed [OFS_W-1:0] ofs_q;
    logic [RAW_W:0]          sum_lo;
    rng_cls_t                cls;
    logic [OUT_W-1:0]        shaped;

    ofsclp_ofs_reg #(
        .OFS_W    (OFS_W),
        .WORD_W   (WORD_W),
        .OFS_LIMIT(OFS_LIMIT)
    ) ofs_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_word(wr_word),
        .ofs_q  (ofs_q),
        .wr_err (wr_err)
    );

    ofsclp_adder #(
        .RAW_W(RAW_W),
        .OFS_W(OFS_W)
    ) adder_i (
        .raw_code(raw_code),
        .ofs     (ofs_q),
        .sum_lo  (sum_lo),
        .cls     (cls)
    );

    ofsclp_shaper #(
        .RAW_W(RAW_W)
    ) shaper_i (
        .sum_lo (sum_lo),
        .cls    (cls),
        .clip_en(clip_en),
        .shaped (shaped)
    );

    // Output register: capture the shaped word on each conversion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (conv_done) begin
            result <= shaped;
        end
    end

    // Valid strobe: one cycle after each conversion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_vld <= 1'b0;
        end else begin
            result_vld <= conv_done;
        end
    end

    // R2: every conversion strobe yields a valid strobe on the next cycle
    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> result_vld);

    // R2: no valid strobe without a conversion in the cycle before
    a_r2_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> !result_vld);

    // R2/R8: the output holds between conversions
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(result));

    // R6: in clip mode a flagged word carries only the all-zero or all-one code
    a_r6_clip_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld && $past(clip_en) && result[OUT_W-1])
            |-> ((result[RAW_W-1:0] == '0) || (&result[RAW_W-1:0])));

    // R5: in clip mode a nominal raw code with zero offset passes unchanged
    a_r5_zero_ofs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && clip_en && (ofs_q == '0)) |=> (result == {1'b0, $past(raw_code)}));

endmodule

// File: tb/ofsclp_top_tb_top.sv
// Bench for ofsclp_top: sweeps all offset field values, all raw codes under
// several offsets and both clip modes, plus same-cycle and hold cases.
module ofsclp_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [12:0] wr_word;
    logic        conv_done;
    logic [11:0] raw_code;
    logic        clip_en;
    logic [12:0] result;
    logic        result_vld;
    logic        wr_err;

    int n_run  = 0;
    int n_fail = 0;
    int cur_ofs = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ofsclp_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .conv_done (conv_done),
        .raw_code  (raw_code),
        .clip_en   (clip_en),
        .result    (result),
        .result_vld(result_vld),
        .wr_err    (wr_err)
    );

    // Model of the output word from the requirements
    function automatic int model(int raw, int ofs, bit clip);
        int s;
        s = raw + ofs;
        if (clip) begin
            if (s < 0)         return 32'h1000;
            else if (s > 4095) return 32'h1FFF;
            else               return s;
        end
        return s & 32'h1FFF;
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Strobe one conversion, then check the registered result and strobe
    task automatic do_conv(int raw, bit clip, string req);
        @(negedge clk);
        conv_done = 1'b1;
        raw_code  = raw[11:0];
        clip_en   = clip;
        @(negedge clk);
        conv_done = 1'b0;
        check(req, int'(result), model(raw, cur_ofs, clip));
        check("R2", int'(result_vld), 1);
    endtask

    // Write a word, update the model offset if legal, check the error pulse
    task automatic do_write(int word, string req);
        int f;
        bit ok;
        f  = (word & 32'h200) ? ((word & 32'h3FF) - 1024) : (word & 32'h3FF);
        ok = ((word >> 10) == 0) && (f >= -327) && (f <= 327);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_word = word[12:0];
        @(negedge clk);
        wr_en = 1'b0;
        check(req, int'(wr_err), ok ? 0 : 1);
        if (ok) cur_ofs = f;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 180000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int offs[6] = '{0, 327, -327, -128, 64, -1};
        rst_n = 1'b0; wr_en = 1'b0; wr_word = '0;
        conv_done = 1'b0; raw_code = '0; clip_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 result", int'(result), 0);
        check("R1 vld", int'(result_vld), 0);
        check("R1 err", int'(wr_err), 0);
        rst_n = 1'b1;
        // R1: reset offset is zero, clip on passes the raw code
        do_conv(100, 1'b1, "R1 offset zero");
        do_conv(4095, 1'b1, "R1 offset zero top");

        // R3/R4: sweep every offset field value, probe with mid-scale code
        for (int f = 0; f < 1024; f++) begin
            do_write(f, "R3/R4 field sweep");
            do_conv(2048, 1'b0, "R3 probe");
        end
        // R3: named encodings -128 and +64
        do_write(13'b0001110000000, "R3 enc -128");
        do_conv(2048, 1'b0, "R3 -128 applied");
        check("R3 -128 value", int'(result), 1920);
        do_write(13'b0000001000000, "R3 enc +64");
        do_conv(2048, 1'b0, "R3 +64 applied");
        check("R3 +64 value", int'(result), 2112);
        // R4: upper bits set are refused, offset kept
        for (int k = 1; k < 8; k++) begin
            do_write((k << 10) | 5, "R4 upper bits");
            do_conv(2048, 1'b0, "R4 offset kept");
            check("R4 kept value", int'(result), 2112);
        end
        // R4: out of range just beyond both limits
        do_write(328, "R4 over +327");
        do_write(1024 - 328, "R4 under -327");
        do_conv(0, 1'b0, "R4 offset kept after range");

        // R3: same-cycle write and conversion uses old offset
        do_write(0, "R3 prep");
        @(negedge clk);
        wr_en = 1'b1; wr_word = 13'd64;
        conv_done = 1'b1; raw_code = 12'd1000; clip_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; conv_done = 1'b0;
        check("R3 same-cycle old offset", int'(result), 1000);
        cur_ofs = 64;
        do_conv(1000, 1'b0, "R3 new offset next");

        // R2/R8: hold after result, clip_en changes ignored
        do_conv(4095, 1'b1, "R6 high clip");
        @(negedge clk);
        check("R2 vld drops", int'(result_vld), 0);
        clip_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 clip ignored after strobe", int'(result), 32'h1FFF);
        check("R2 still no vld", int'(result_vld), 0);

        // R5/R6/R7: full raw sweep under several offsets, both modes
        foreach (offs[i]) begin
            do_write(offs[i] & 32'h3FF, "R3 sweep write");
            for (int r = 0; r < 4096; r++) begin
                do_conv(r, 1'b1, "R5/R6 clip sweep");
                do_conv(r, 1'b0, "R7 wrap sweep");
            end
        end
        // R6/R7: explicit boundary values
        do_write(327, "R6 prep");
        do_conv(4095, 1'b0, "R7 top wrap");
        check("R7 top wrap value", int'(result), 32'h1146);
        do_conv(3768, 1'b1, "R5 edge in range");
        check("R5 edge value", int'(result), 4095);
        do_conv(3769, 1'b1, "R6 edge above");
        check("R6 edge above value", int'(result), 32'h1FFF);
        do_write(1024 - 327, "R6 prep low");
        do_conv(0, 1'b0, "R7 bottom wrap");
        check("R7 bottom wrap value", int'(result), 32'h1EB9);
        do_conv(326, 1'b1, "R6 edge below");
        check("R6 edge below value", int'(result), 32'h1000);
        do_conv(327, 1'b1, "R5 edge zero");
        check("R5 edge zero value", int'(result), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule